// File: doc/BRIEF.md
# Serial Bitstream Byte Receiver with Data Request

This block is the slave side of a serial link that carries a compressed-audio bitstream from a host. The host drives a serial clock, a data line and a data-select line. The block assembles the bits into bytes, most significant bit first, and moves each finished byte into the system clock domain. There the byte is stored in a byte FIFO, which a downstream consumer drains through a simple pop port. A level request output tells the host whether it may keep sending. The request falls early enough that the host can still finish one burst after it drops.

A legacy framing mode is available. In that mode, a sync strobe that is high together with the first bit marks the start of each byte. Bits clocked with select low are ignored. This lets the same serial clock carry a control-port transaction between two data bytes without corrupting either byte.

The block also checks every received byte against a fixed eight-byte test-entry pattern and raises a sticky flag on a match.

Top module: `sdi_byte_rx`

## Requirements
- R1: In normal mode (`compat_mode`=0), each rising `sclk` edge with `dsel`=1 shifts in one bit of `sdata`. The first bit becomes bit 7 of the byte and the eighth bit becomes bit 0.
- R2: A rising `sclk` edge with `dsel`=0 stores no bit and discards any partly received byte. A byte sent after such edges, and the bytes before them, arrive intact.
- R3: In legacy mode (`compat_mode`=1), a bit clocked with `sync_in`=1 is taken as bit 7 of a new byte and discards any partial byte. Bits clocked before the first sync of a byte are ignored.
- R4: Every completed byte enters the FIFO, and `has_data` becomes 1 no later than four system clocks after the `sclk` edge that carried bit 0. Pulsing `pop` while `has_data`=1 gives `pop_valid`=1 and the next byte on `pop_data` one clock later. Bytes come out in arrival order.
- R5: `req` is 1 while more than FREE_MIN (default 32) of the DEPTH (default 64) slots are free. It is 0 once FREE_MIN or fewer slots are free, which means 32 or more bytes are stored with the defaults.
- R6: A byte that completes while the FIFO holds DEPTH bytes is dropped. When that happens `overflow` goes to 1 and stays 1 until reset. The stored bytes are not affected.
- R7: `test_hit` goes to 1, and stays 1 until reset, after the eight consecutive bytes 0x50, 0xED, 0x6E, 0x54, 0x00, 0x00, 0x00, 0x00.
- R8: When a received byte does not continue the pattern match, the match restarts. That same byte is then checked as a possible first byte of the pattern.
- R9: After reset, `req`=1 and `has_data`, `pop_valid`, `overflow` and `test_hit` are all 0. Reset is synchronous to both clocks, so `sclk` must toggle while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, applied in both clock domains |
| sclk | input | 1 | Serial bit clock from the host |
| sdata | input | 1 | Serial data, sampled on rising `sclk` |
| dsel | input | 1 | Data select, active high |
| sync_in | input | 1 | Byte-start strobe used in legacy mode |
| compat_mode | input | 1 | 1 selects legacy sync-strobe framing |
| pop | input | 1 | Request to read one byte from the FIFO |
| pop_valid | output | 1 | `pop_data` holds a popped byte |
| pop_data | output | 8 | Popped byte |
| has_data | output | 1 | FIFO is not empty |
| req | output | 1 | Host may send more data |
| overflow | output | 1 | Sticky: a byte was dropped on a full FIFO |
| test_hit | output | 1 | Sticky: the test-entry pattern was seen |

## Verification
A finished byte crosses a two-flop synchronizer and one edge register before it is written. `has_data`, `req`, `overflow` and `test_hit` therefore settle by the third system clock edge after the `sclk` edge that carried bit 0. The bench aligns `sclk` edges to system falling edges and samples these flags at least 20 ns (four system clocks) after that edge, or only after a further settling wait. `pop_valid` and `pop_data` follow a pop by exactly one clock. The monitor compares them at the next falling edge against the front of the expected-byte queue, so it does not depend on when the driver sent the byte.

// File: rtl/sdi_rx_pkg.sv
package sdi_rx_pkg;
  localparam int BYTE_W  = 8;
  localparam int SEQ_LEN = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  localparam byte_t TEST_SEQ [SEQ_LEN] = '{8'h50, 8'hED, 8'h6E, 8'h54, 8'h00, 8'h00, 8'h00, 8'h00};
endpackage

// File: rtl/sdi_shift.sv
module sdi_shift #(
  parameter int W = 8
) (
  input  logic         sclk,
  input  logic         rst,
  input  logic         sdata,
  input  logic         dsel,
  input  logic         sync_in,
  input  logic         compat_mode,
  output logic [W-1:0] byte_q,
  output logic         tog_q
);
  localparam int CW = $clog2(W);

  logic [W-2:0] sh;
  logic [CW-1:0] cnt;
  logic          act;

  always_ff @(posedge sclk) begin
    if (rst) begin
      sh     <= '0;
      cnt    <= '0;
      act    <= 1'b0;
      byte_q <= '0;
      tog_q  <= 1'b0;
    end else if (!dsel) begin
      cnt <= '0;
      act <= 1'b0;
    end else if (compat_mode && sync_in) begin
      sh  <= {{(W-2){1'b0}}, sdata};
      cnt <= CW'(1);
      act <= 1'b1;
    end else if (!compat_mode || act) begin
      if (cnt == CW'(W-1)) begin
        byte_q <= {sh, sdata};
        tog_q  <= ~tog_q;
        cnt    <= '0;
        act    <= 1'b0;
      end else begin
        sh  <= {sh[W-3:0], sdata};
        cnt <= cnt + 1'b1;
        act <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdi_fifo.sv
module sdi_fifo #(
  parameter int W        = 8,
  parameter int DEPTH    = 64,
  parameter int FREE_MIN = 32,
  localparam int AW      = $clog2(DEPTH),
  localparam int CNTW    = AW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [W-1:0]    wr_data,
  input  logic            rd_en,
  output logic            rd_valid,
  output logic [W-1:0]    rd_data,
  output logic            not_empty,
  output logic            room_req,
  output logic            ovf,
  output logic [CNTW-1:0] cnt
);
  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [CNTW-1:0] cnt_nxt;
  logic            full, do_wr, do_rd;

  assign full    = (cnt == CNTW'(DEPTH));
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && (cnt != '0);
  assign cnt_nxt = cnt + CNTW'(do_wr) - CNTW'(do_rd);

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
    if (do_rd) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      cnt       <= '0;
      rd_valid  <= 1'b0;
      not_empty <= 1'b0;
      room_req  <= 1'b1;
      ovf       <= 1'b0;
    end else begin
      if (do_wr) wr_ptr <= wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= rd_ptr + 1'b1;
      cnt       <= cnt_nxt;
      rd_valid  <= do_rd;
      not_empty <= (cnt_nxt != '0);
      room_req  <= (CNTW'(DEPTH) - cnt_nxt) > CNTW'(FREE_MIN);
      if (wr_en && full) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/sdi_seq_det.sv
module sdi_seq_det
  import sdi_rx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  in_vld,
  input  byte_t in_byte,
  output logic  hit
);
  localparam int IW = $clog2(SEQ_LEN);

  logic [IW-1:0] idx;
  logic          match;

  assign match = (in_byte == TEST_SEQ[idx]);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
      hit <= 1'b0;
    end else if (in_vld) begin
      if (match) begin
        if (idx == IW'(SEQ_LEN-1)) begin
          idx <= '0;
          hit <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end else begin
        idx <= (in_byte == TEST_SEQ[0]) ? IW'(1) : '0;
      end
    end
  end
endmodule

// File: rtl/sdi_byte_rx.sv
module sdi_byte_rx
  import sdi_rx_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int FREE_MIN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              dsel,
  input  logic              sync_in,
  input  logic              compat_mode,
  input  logic              pop,
  output logic              pop_valid,
  output logic [BYTE_W-1:0] pop_data,
  output logic              has_data,
  output logic              req,
  output logic              overflow,
  output logic              test_hit
);
  localparam int CNTW = $clog2(DEPTH) + 1;

  byte_t           ser_byte;
  logic            ser_tog;
  logic [2:0]      tog_sync;
  logic            byte_push;
  logic [CNTW-1:0] fifo_cnt;

  sdi_shift #(.W(BYTE_W)) u_shift (
    .sclk(sclk), .rst(rst), .sdata(sdata), .dsel(dsel), .sync_in(sync_in),
    .compat_mode(compat_mode), .byte_q(ser_byte), .tog_q(ser_tog)
  );

  always_ff @(posedge clk) begin
    if (rst) tog_sync <= '0;
    else     tog_sync <= {tog_sync[1:0], ser_tog};
  end

  assign byte_push = tog_sync[2] ^ tog_sync[1];

  sdi_fifo #(.W(BYTE_W), .DEPTH(DEPTH), .FREE_MIN(FREE_MIN)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(byte_push), .wr_data(ser_byte), .rd_en(pop),
    .rd_valid(pop_valid), .rd_data(pop_data), .not_empty(has_data),
    .room_req(req), .ovf(overflow), .cnt(fifo_cnt)
  );

  sdi_seq_det u_seq (
    .clk(clk), .rst(rst), .in_vld(byte_push), .in_byte(ser_byte), .hit(test_hit)
  );
endmodule

// File: rtl/sdi_byte_rx_chk.sv
module sdi_byte_rx_chk #(
  parameter int DEPTH    = 64,
  parameter int FREE_MIN = 32,
  parameter int CNTW     = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            pop,
  input logic            pop_valid,
  input logic            has_data,
  input logic            req,
  input logic            overflow,
  input logic            test_hit,
  input logic            byte_push,
  input logic [CNTW-1:0] fifo_cnt
);
  AST_POP_VALID:   assert property (@(posedge clk) disable iff (rst) pop_valid |-> ($past(pop) && $past(has_data))); // R4
  AST_REQ_LEVEL:   assert property (@(posedge clk) disable iff (rst) !req |-> ((CNTW'(DEPTH) - fifo_cnt) <= CNTW'(FREE_MIN))); // R5
  AST_CNT_BOUND:   assert property (@(posedge clk) disable iff (rst) fifo_cnt <= CNTW'(DEPTH)); // R6
  AST_OVF_STICKY:  assert property (@(posedge clk) disable iff (rst) overflow |=> overflow); // R6
  AST_OVF_CAUSE:   assert property (@(posedge clk) disable iff (rst) $rose(overflow) |-> ($past(byte_push) && $past(fifo_cnt) == CNTW'(DEPTH))); // R6
  AST_HIT_STICKY:  assert property (@(posedge clk) disable iff (rst) test_hit |=> test_hit); // R7
  AST_HIT_CAUSE:   assert property (@(posedge clk) disable iff (rst) $rose(test_hit) |-> $past(byte_push)); // R7
endmodule

bind sdi_byte_rx sdi_byte_rx_chk #(.DEPTH(DEPTH), .FREE_MIN(FREE_MIN), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst(rst), .pop(pop), .pop_valid(pop_valid), .has_data(has_data),
  .req(req), .overflow(overflow), .test_hit(test_hit), .byte_push(byte_push),
  .fifo_cnt(fifo_cnt)
);

// File: tb/sdi_byte_rx_bench.sv
module sdi_byte_rx_bench;
  logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, sdata = 1'b0, dsel = 1'b0;
  logic sync_in = 1'b0, compat_mode = 1'b0, pop = 1'b0;
  logic pop_valid, has_data, req, overflow, test_hit;
  logic [7:0] pop_data;
  logic drain_en = 1'b0;
  logic [7:0] exp_q [$];
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  sdi_byte_rx u_sdi_byte_rx (
    .clk(clk), .rst(rst), .sclk(sclk), .sdata(sdata), .dsel(dsel), .sync_in(sync_in),
    .compat_mode(compat_mode), .pop(pop), .pop_valid(pop_valid), .pop_data(pop_data),
    .has_data(has_data), .req(req), .overflow(overflow), .test_hit(test_hit)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clk_bit(input logic d, input logic sel, input logic syn);
    sdata = d; dsel = sel; sync_in = syn;
    #20 sclk = 1'b1;
    #20 sclk = 1'b0;
  endtask

  task automatic send_bits(input logic [7:0] v, input int n, input logic syn_first);
    @(negedge clk);
    for (int i = 0; i < n; i++) clk_bit(v[7-i], 1'b1, syn_first && i == 0);
    sync_in = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, input logic stored);
    if (stored) exp_q.push_back(v);
    send_bits(v, 8, compat_mode);
  endtask

  task automatic idle_clocks(input int n);
    @(negedge clk);
    for (int i = 0; i < n; i++) clk_bit(i[0], 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    rst = 1'b1; dsel = 1'b0; drain_en = 1'b0;
    idle_clocks(3);
    @(negedge clk) rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (pop_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R4: actual=%0h expected=none (unexpected byte)", pop_data);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          if (pop_data !== e) begin
            errors++;
            $display("FAIL R4/R1: actual=%0h expected=%0h", pop_data, e);
          end
        end
      end
      pop = drain_en && has_data && !rst;
    end
  end

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R9 reset state
    check(req == 1'b1, "R9 req", req, 1);
    check(has_data == 1'b0, "R9 has_data", has_data, 0);
    check(pop_valid == 1'b0, "R9 pop_valid", pop_valid, 0);
    check(overflow == 1'b0, "R9 overflow", overflow, 0);
    check(test_hit == 1'b0, "R9 test_hit", test_hit, 0);

    // R4 latency: first byte visible within four system clocks
    send_byte(8'hA5, 1'b1);
    check(has_data == 1'b1, "R4 latency", has_data, 1);
    drain_en = 1'b1;
    repeat (10) @(negedge clk);

    // R1 several patterns, MSB first
    send_byte(8'h80, 1'b1);
    send_byte(8'h01, 1'b1);
    send_byte(8'h3C, 1'b1);
    send_byte(8'hFF, 1'b1);
    send_byte(8'h00, 1'b1);

    // R2 partial byte discarded, control traffic between bytes
    send_bits(8'hF8, 5, 1'b0);
    idle_clocks(2);
    send_byte(8'h96, 1'b1);
    idle_clocks(16);
    send_byte(8'h69, 1'b1);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R2 bytes delivered", exp_q.size(), 0);
    check(has_data == 1'b0, "R2 no extra byte", has_data, 0);

    // R3 legacy framing
    idle_clocks(1);
    compat_mode = 1'b1;
    send_bits(8'hE0, 3, 1'b0);        // no sync: ignored
    send_byte(8'hC3, 1'b1);
    send_bits(8'hF0, 4, 1'b1);        // restarted by next sync
    send_byte(8'h5A, 1'b1);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R3 legacy bytes", exp_q.size(), 0);
    check(has_data == 1'b0, "R3 no stray byte", has_data, 0);
    idle_clocks(1);
    compat_mode = 1'b0;

    // R7/R8 pattern detection
    send_byte(8'h50, 1'b1); send_byte(8'hED, 1'b1); send_byte(8'h6E, 1'b1);
    send_byte(8'h54, 1'b1); send_byte(8'h00, 1'b1); send_byte(8'h00, 1'b1);
    send_byte(8'h00, 1'b1); send_byte(8'h11, 1'b1);
    repeat (10) @(negedge clk);
    check(test_hit == 1'b0, "R7 no hit on broken pattern", test_hit, 0);
    send_byte(8'h50, 1'b1); send_byte(8'hED, 1'b1);
    send_byte(8'h50, 1'b1); send_byte(8'hED, 1'b1); send_byte(8'h6E, 1'b1);
    send_byte(8'h54, 1'b1); send_byte(8'h00, 1'b1); send_byte(8'h00, 1'b1);
    send_byte(8'h00, 1'b1);
    repeat (10) @(negedge clk);
    check(test_hit == 1'b0, "R8 one byte short", test_hit, 0);
    send_byte(8'h00, 1'b1);
    repeat (10) @(negedge clk);
    check(test_hit == 1'b1, "R8 hit after restart", test_hit, 1);
    repeat (10) @(negedge clk);
    check(test_hit == 1'b1, "R7 sticky", test_hit, 1);
    check(exp_q.size() == 0, "R4 pattern bytes delivered", exp_q.size(), 0);

    // R5/R6 request level and overflow
    do_reset();
    check(test_hit == 1'b0, "R9 hit cleared", test_hit, 0);
    for (int i = 0; i < 31; i++) send_byte(8'(i + 8'h10), 1'b1);
    repeat (6) @(negedge clk);
    check(req == 1'b1, "R5 req at 31 stored", req, 1);
    send_byte(8'h2F, 1'b1);
    repeat (6) @(negedge clk);
    check(req == 1'b0, "R5 req at 32 stored", req, 0);
    for (int i = 0; i < 32; i++) send_byte(8'(i + 8'h80), 1'b1);
    repeat (6) @(negedge clk);
    check(overflow == 1'b0, "R6 full without drop", overflow, 0);
    send_byte(8'hEE, 1'b0);
    repeat (6) @(negedge clk);
    check(overflow == 1'b1, "R6 overflow set", overflow, 1);
    drain_en = 1'b1;
    repeat (200) @(negedge clk);
    check(exp_q.size() == 0, "R6 stored bytes intact", exp_q.size(), 0);
    check(req == 1'b1, "R5 req after drain", req, 1);
    check(overflow == 1'b1, "R6 overflow sticky", overflow, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule